// File: doc/BRIEF.md
# Memory String Operation Engine

This engine carries out one multicycle string operation over memory each time it is started. The caller supplies a destination pointer, a second operand that is either a source pointer or a pattern value, a count, an operation code and an element size. The engine then walks memory through a single read/write port, one element at a time. When it finishes it presents the updated pointers, the remaining count and the zero (Z) and carry (C) flags.

Seven operations are supported: byte copy upward and downward, byte copy that stops on a zero byte, fill with a pattern, two searches (stop on match, stop on mismatch) and a byte-wise string compare. All of them are handled by one sequencer. What differs between them is the termination rule, the step direction, the element size and whether the flags are written.

Top module: `strop_engine`

## Requirements
- R1: Operation code 0 (copy up) repeats, while count is not zero: read a byte at the source pointer, write it at the destination pointer, add 1 to both pointers and subtract 1 from count.
- R2: Operation code 1 (copy down) behaves like code 0 except that both pointers are decremented by 1 after each byte.
- R3: Operation code 2 (copy to terminator) copies bytes like code 0, and stops after writing a zero byte or when count reaches zero. The zero byte is itself copied, and the count and pointers are updated for it.
- R4: Operation code 3 (fill) writes the low 1, 2 or 4 bytes of the pattern operand at the destination pointer, adds that byte count to the pointer and subtracts 1 from count, until count is zero. The size code is 0 for byte, 1 for halfword and 2 or 3 for word.
- R5: Operation codes 4 (search until match) and 5 (search while match) repeat three steps: decrement count, read one element at the destination pointer, advance that pointer by the element size. Code 4 stops on the first element equal to the pattern and code 5 on the first unequal one; both also stop when count reaches zero.
- R6: A zero starting count performs no memory access and leaves pointers and count unchanged. For copy, fill and search it also leaves both flags unchanged. For compare it sets Z=1 and C=1.
- R7: Before a search compares, the pattern is cut to the element size, so upper pattern bits above the element have no effect.
- R8: Operation code 6 (compare) reads a byte at the destination pointer (first value) and a byte at the source pointer (second value), increments both pointers and decrements count. It stops when the bytes differ, when the first byte is zero, or when count reaches zero.
- R9: At the end of a compare or search, equal last values give Z=1 and C=1. Otherwise Z=0, and C=1 exactly when the first value is greater than or equal to the second, both taken as unsigned. For a search the first value is the size-masked pattern and the second is the last element read.
- R10: Copy and fill operations never change Z or C.
- R11: A start pulse is accepted only while idle; a start seen while busy is ignored. busy is high from the cycle after acceptance until the last step, done is a single-cycle pulse with busy low, and the final pointer, count and flag values are valid when done is high.
- R12: The memory port issues at most one read or one write at a time. A request holds its address, size and data until acknowledged. Read data is taken from the low bits of memRdata in little-endian byte order, and write data is placed in the low bits of memWdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opSel | input | 3 | Operation code (0..6) |
| sizeSel | input | 2 | Element size for fill and search (0 byte, 1 half, 2/3 word) |
| dstIn | input | AW | Starting destination pointer |
| srcIn | input | AW | Starting source pointer, or pattern value |
| cntIn | input | CW | Starting element count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dstOut | output | AW | Current destination pointer |
| srcOut | output | AW | Current source pointer or pattern |
| cntOut | output | CW | Current remaining count |
| zFlag | output | 1 | Zero flag |
| cFlag | output | 1 | Carry flag |
| memRd | output | 1 | Read request |
| memWr | output | 1 | Write request |
| memAddr | output | AW | Access address |
| memSize | output | 2 | Access size code |
| memWdata | output | 32 | Write data, low bytes valid |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Completes the pending request this cycle |

## Verification
An error in the sequencer state shows up almost immediately at the memory port: an extra or missing access, a read where a write belongs, or a write to the wrong address or with the wrong data. Each write is compared with the reference at its acknowledge, so such errors are caught within one element. Errors in the pointer, count or flag registers reach the ports only at the done pulse, and usually only after several elements of a multi-element run. For that reason the runs are long enough for an off-by-one in a termination rule to move the final pointer or count. Wrong latched comparison values show up as wrong flags, or as a search or compare that stops at the wrong element.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_FWD     = 3'd0,
    OP_BWD     = 3'd1,
    OP_CUZ     = 3'd2,
    OP_FILL    = 3'd3,
    OP_SRCH_EQ = 3'd4,
    OP_SRCH_NE = 3'd5,
    OP_CMP     = 3'd6
  } strOp_e;

  typedef struct packed {
    logic load;
    logic latchA;
    logic latchB;
    logic stepD;
    logic stepS;
    logic decCnt;
    logic setFlags;
  } strCtrl_t;

  function automatic logic [31:0] maskBySize(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    maskBySize = {24'd0, v[7:0]};
      2'd1:    maskBySize = {16'd0, v[15:0]};
      default: maskBySize = v;
    endcase
  endfunction

endpackage

// File: rtl/strop_datapath.sv
module strop_datapath
  import strop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  strCtrl_t      ctrl,
  input  logic [2:0]    opSel,
  input  logic [1:0]    sizeSel,
  input  logic [AW-1:0] dstIn,
  input  logic [AW-1:0] srcIn,
  input  logic [CW-1:0] cntIn,
  input  logic [31:0]   memRdata,
  output logic [AW-1:0] dPtr,
  output logic [AW-1:0] sPtr,
  output logic [CW-1:0] cnt,
  output logic [2:0]    opR,
  output logic          zFlag,
  output logic          cFlag,
  output logic          cntZero,
  output logic          valEq,
  output logic          aZero,
  output logic          bZero,
  output logic [1:0]    accSize,
  output logic [31:0]   wData
);

  logic [1:0]  sizeR;
  logic [31:0] aVal, bVal, patt, firstV, secondV;
  logic [AW-1:0] elemStep;
  logic isSearch, isWide, isDown;

  assign isSearch = (opR == OP_SRCH_EQ) || (opR == OP_SRCH_NE);
  assign isWide   = isSearch || (opR == OP_FILL);
  assign isDown   = (opR == OP_BWD);
  assign accSize  = isWide ? sizeR : 2'd0;
  assign patt     = 32'(sPtr);

  always_comb begin
    case (accSize)
      2'd0:    elemStep = AW'(1);
      2'd1:    elemStep = AW'(2);
      default: elemStep = AW'(4);
    endcase
  end

  assign firstV  = isSearch ? maskBySize(patt, sizeR) : aVal;
  assign secondV = isSearch ? aVal : bVal;
  assign valEq   = (firstV == secondV);
  assign cntZero = (cnt == '0);
  assign aZero   = (aVal[7:0] == 8'd0);
  assign bZero   = (bVal[7:0] == 8'd0);
  assign wData   = (opR == OP_FILL) ? maskBySize(patt, sizeR) : bVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dPtr  <= '0;
      sPtr  <= '0;
      cnt   <= '0;
      opR   <= '0;
      sizeR <= '0;
      aVal  <= '0;
      bVal  <= '0;
      zFlag <= 1'b0;
      cFlag <= 1'b0;
    end else begin
      if (ctrl.load) begin
        dPtr  <= dstIn;
        sPtr  <= srcIn;
        cnt   <= cntIn;
        opR   <= opSel;
        sizeR <= sizeSel;
        aVal  <= '0;
        bVal  <= '0;
      end
      if (ctrl.latchA) aVal <= maskBySize(memRdata, accSize);
      if (ctrl.latchB) bVal <= {24'd0, memRdata[7:0]};
      if (ctrl.stepD)  dPtr <= isDown ? dPtr - elemStep : dPtr + elemStep;
      if (ctrl.stepS)  sPtr <= isDown ? sPtr - AW'(1) : sPtr + AW'(1);
      if (ctrl.decCnt) cnt  <= cnt - CW'(1);
      if (ctrl.setFlags) begin
        zFlag <= valEq;
        cFlag <= (firstV >= secondV);
      end
    end
  end

endmodule

// File: rtl/strop_control.sv
module strop_control
  import strop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opR,
  input  logic       cntZero,
  input  logic       valEq,
  input  logic       aZero,
  input  logic       bZero,
  input  logic       memAck,
  output strCtrl_t   ctrl,
  output logic       memRd,
  output logic       memWr,
  output logic       addrSrc,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_TEST, ST_RDA, ST_RDB, ST_WR, ST_EVAL, ST_DONE
  } state_e;

  state_e st, nxt;
  logic isCopy, stopNow;

  assign isCopy = (opR == OP_FWD) || (opR == OP_BWD) || (opR == OP_CUZ);

  always_comb begin
    if (opR == OP_CMP)         stopNow = !valEq || aZero || cntZero;
    else if (opR == OP_SRCH_EQ) stopNow = valEq || cntZero;
    else                        stopNow = !valEq || cntZero;
  end

  always_comb begin
    ctrl    = '0;
    memRd   = 1'b0;
    memWr   = 1'b0;
    addrSrc = 1'b0;
    nxt     = st;
    case (st)
      ST_IDLE: if (start) begin
        ctrl.load = 1'b1;
        nxt = ST_TEST;
      end
      ST_TEST: begin
        if (cntZero) begin
          ctrl.setFlags = (opR == OP_CMP);
          nxt = ST_DONE;
        end else if (isCopy) begin
          nxt = ST_RDB;
        end else if (opR == OP_FILL) begin
          nxt = ST_WR;
        end else if (opR == OP_CMP) begin
          nxt = ST_RDA;
        end else if (opR == OP_SRCH_EQ || opR == OP_SRCH_NE) begin
          ctrl.decCnt = 1'b1;
          nxt = ST_RDA;
        end else begin
          nxt = ST_DONE;
        end
      end
      ST_RDA: begin
        memRd = 1'b1;
        if (memAck) begin
          ctrl.latchA = 1'b1;
          ctrl.stepD  = 1'b1;
          nxt = (opR == OP_CMP) ? ST_RDB : ST_EVAL;
        end
      end
      ST_RDB: begin
        memRd   = 1'b1;
        addrSrc = 1'b1;
        if (memAck) begin
          ctrl.latchB = 1'b1;
          ctrl.stepS  = 1'b1;
          if (opR == OP_CMP) begin
            ctrl.decCnt = 1'b1;
            nxt = ST_EVAL;
          end else begin
            nxt = ST_WR;
          end
        end
      end
      ST_WR: begin
        memWr = 1'b1;
        if (memAck) begin
          ctrl.stepD  = 1'b1;
          ctrl.decCnt = 1'b1;
          nxt = (opR == OP_CUZ && bZero) ? ST_DONE : ST_TEST;
        end
      end
      ST_EVAL: begin
        if (stopNow) begin
          ctrl.setFlags = 1'b1;
          nxt = ST_DONE;
        end else begin
          nxt = ST_TEST;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= nxt;
  end

  assign busy = (st != ST_IDLE) && (st != ST_DONE);
  assign done = (st == ST_DONE);

endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [2:0]    opSel,
  input  logic [1:0]    sizeSel,
  input  logic [AW-1:0] dstIn,
  input  logic [AW-1:0] srcIn,
  input  logic [CW-1:0] cntIn,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] dstOut,
  output logic [AW-1:0] srcOut,
  output logic [CW-1:0] cntOut,
  output logic          zFlag,
  output logic          cFlag,
  output logic          memRd,
  output logic          memWr,
  output logic [AW-1:0] memAddr,
  output logic [1:0]    memSize,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memAck
);

  strCtrl_t ctrl;
  logic [2:0] opR;
  logic cntZero, valEq, aZero, bZero, addrSrc;

  strop_control u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .opR(opR),
    .cntZero(cntZero), .valEq(valEq), .aZero(aZero), .bZero(bZero),
    .memAck(memAck), .ctrl(ctrl), .memRd(memRd), .memWr(memWr),
    .addrSrc(addrSrc), .busy(busy), .done(done)
  );

  strop_datapath #(.AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opSel(opSel), .sizeSel(sizeSel),
    .dstIn(dstIn), .srcIn(srcIn), .cntIn(cntIn), .memRdata(memRdata),
    .dPtr(dstOut), .sPtr(srcOut), .cnt(cntOut), .opR(opR),
    .zFlag(zFlag), .cFlag(cFlag), .cntZero(cntZero), .valEq(valEq),
    .aZero(aZero), .bZero(bZero), .accSize(memSize), .wData(memWdata)
  );

  assign memAddr = addrSrc ? srcOut : dstOut;

endmodule

// File: rtl/strop_checker.sv
module strop_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [2:0]    opSel,
  input logic          busy,
  input logic          done,
  input logic          memRd,
  input logic          memWr,
  input logic          memAck,
  input logic [AW-1:0] memAddr,
  input logic [1:0]    memSize,
  input logic          zFlag,
  input logic          cFlag
);

  logic [2:0] opCap;
  logic zCap, cCap, capValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opCap <= '0; zCap <= 1'b0; cCap <= 1'b0; capValid <= 1'b0;
    end else if (start && !busy && !done) begin
      opCap <= opSel; zCap <= zFlag; cCap <= cFlag; capValid <= 1'b1;
    end
  end

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr)); // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ((memRd || memWr) && !memAck) |=> ((memRd || memWr) && $stable(memAddr) && $stable(memSize))); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R11

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !memWr)); // R11

  AST_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (done && capValid && opCap <= 3'd3) |-> (zFlag == zCap && cFlag == cCap)); // R10

endmodule

bind strop_engine strop_checker #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .busy(busy),
  .done(done), .memRd(memRd), .memWr(memWr), .memAck(memAck),
  .memAddr(memAddr), .memSize(memSize), .zFlag(zFlag), .cFlag(cFlag)
);

// File: tb/sim_strop_engine.sv
`timescale 1ns/1ps
module sim_strop_engine;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, start, busy, done, zFlag, cFlag, memRd, memWr, memAck;
  logic [2:0] opSel;
  logic [1:0] sizeSel, memSize;
  logic [31:0] dstIn, srcIn, cntIn, dstOut, srcOut, cntOut, memAddr, memWdata, memRdata;

  strop_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .sizeSel(sizeSel),
    .dstIn(dstIn), .srcIn(srcIn), .cntIn(cntIn), .busy(busy), .done(done),
    .dstOut(dstOut), .srcOut(srcOut), .cntOut(cntOut), .zFlag(zFlag), .cFlag(cFlag),
    .memRd(memRd), .memWr(memWr), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  logic [31:0] expA[$], expD[$];
  logic [1:0]  expS[$];
  int nRun = 0, nFail = 0;
  int waitCnt = 0, lat = 0;
  logic running = 1'b0;
  string curTag = "";
  logic refZ = 1'b0, refC = 1'b0;
  logic [31:0] expDst, expSrc, expCnt;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] szMask(input logic [31:0] v, input logic [1:0] sz);
    return (sz == 2'd0) ? (v & 32'hFF) : (sz == 2'd1) ? (v & 32'hFFFF) : v;
  endfunction

  // memory responder: acknowledge after 0..2 wait cycles, check every write
  always @(negedge clk) begin
    memAck = 1'b0;
    if (rstN && (memRd || memWr)) begin
      if (waitCnt >= lat) begin
        memAck = 1'b1;
        waitCnt = 0;
        lat = (lat + 1) % 3;
        if (memRd) begin
          memRdata = 32'd0;
          for (int i = 0; i < nBytes(memSize); i++)
            memRdata[8*i +: 8] = mem[8'(memAddr + i)];
        end else begin
          if (expA.size() == 0) begin
            chk(1'b0, "R12", "unexpected write addr", memAddr, 32'hFFFFFFFF);
          end else begin
            logic [31:0] a, d; logic [1:0] s;
            a = expA.pop_front(); d = expD.pop_front(); s = expS.pop_front();
            chk(memAddr == a, curTag, "write address", memAddr, a);
            chk(memSize == s, curTag, "write size", 32'(memSize), 32'(s));
            chk(szMask(memWdata, memSize) == d, curTag, "write data", szMask(memWdata, memSize), d);
          end
          for (int i = 0; i < nBytes(memSize); i++)
            mem[8'(memAddr + i)] = memWdata[8*i +: 8];
        end
      end else begin
        waitCnt++;
      end
    end else begin
      waitCnt = 0;
    end
    if (running && !done && !busy)
      chk(1'b0, "R11", "busy low while running", 32'(busy), 32'd1);
  end

  task automatic refWrite(input logic [31:0] a, input logic [31:0] d, input logic [1:0] s);
    expA.push_back(a); expD.push_back(szMask(d, s)); expS.push_back(s);
    for (int i = 0; i < nBytes(s); i++) refMem[8'(a + i)] = d[8*i +: 8];
  endtask

  function automatic logic [31:0] refRead(input logic [31:0] a, input logic [1:0] s);
    logic [31:0] v = 32'd0;
    for (int i = 0; i < nBytes(s); i++) v[8*i +: 8] = refMem[8'(a + i)];
    return v;
  endfunction

  // behavioural reference run, built from the requirements
  task automatic refModel(input logic [2:0] op, input logic [1:0] sz,
                          input logic [31:0] d0, input logic [31:0] s0, input logic [31:0] c0);
    logic [31:0] d = d0, s = s0, c = c0, u, v, a, b;
    for (int i = 0; i < 256; i++) refMem[i] = mem[i];
    case (op)
      3'd0, 3'd1, 3'd2: begin
        while (c != 0) begin
          b = {24'd0, refMem[8'(s)]};
          refWrite(d, b, 2'd0);
          if (op == 3'd1) begin d--; s--; end else begin d++; s++; end
          c--;
          if (op == 3'd2 && b == 0) break;
        end
      end
      3'd3: begin
        while (c != 0) begin
          refWrite(d, s, sz);
          d += nBytes(sz); c--;
        end
      end
      3'd4, 3'd5: begin
        if (c != 0) begin
          u = szMask(s, sz); v = 32'd0;
          while (c != 0) begin
            c--;
            v = refRead(d, sz);
            d += nBytes(sz);
            if (op == 3'd4 ? (v == u) : (v != u)) break;
          end
          refZ = (u == v); refC = (u >= v);
        end
      end
      default: begin
        a = 0; b = 0;
        while (c != 0) begin
          a = {24'd0, refMem[8'(d)]}; b = {24'd0, refMem[8'(s)]};
          d++; s++; c--;
          if (a != b || a == 0) break;
        end
        refZ = (a == b); refC = (a >= b);
      end
    endcase
    expDst = d; expSrc = s; expCnt = c;
  endtask

  task automatic runOp(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] d0,
                       input logic [31:0] s0, input logic [31:0] c0, input string tag,
                       input logic poke);
    int k;
    curTag = tag;
    refModel(op, sz, d0, s0, c0);
    @(negedge clk);
    opSel = op; sizeSel = sz; dstIn = d0; srcIn = s0; cntIn = c0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; running = 1'b1;
    if (poke) begin
      opSel = 3'd3; dstIn = 32'h0; srcIn = 32'hFFFF_FFFF; cntIn = 32'd50; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    k = 0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    if (!done) begin
      chk(1'b0, tag, "watchdog, no done", 32'(k), 32'd0);
    end else begin
      chk(!busy, "R11", "busy with done", 32'(busy), 32'd0);
      chk(dstOut == expDst, tag, "final destination pointer", dstOut, expDst);
      chk(srcOut == expSrc, tag, "final source pointer", srcOut, expSrc);
      chk(cntOut == expCnt, tag, "final count", cntOut, expCnt);
      chk(zFlag == refZ, tag, "Z flag", 32'(zFlag), 32'(refZ));
      chk(cFlag == refC, tag, "C flag", 32'(cFlag), 32'(refC));
      chk(expA.size() == 0, tag, "missing writes", 32'(expA.size()), 32'd0);
      begin
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) bad++;
        chk(bad == 0, tag, "memory image mismatches", 32'(bad), 32'd0);
      end
      @(negedge clk);
      chk(!done, "R11", "done longer than one cycle", 32'(done), 32'd0);
    end
    running = 1'b0;
    expA.delete(); expD.delete(); expS.delete();
  endtask

  task automatic putBytes(input logic [31:0] a, input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) mem[8'(a + i)] = v[8*i +: 8];
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; opSel = 3'd0; sizeSel = 2'd0;
    dstIn = 0; srcIn = 0; cntIn = 0; memAck = 1'b0; memRdata = 0;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 7 + 3) | 1);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R11", "reset busy/done", {30'd0, busy, done}, 32'd0);
    chk(!zFlag && !cFlag, "R9", "reset flags", {30'd0, zFlag, cFlag}, 32'd0);
    chk(!memRd && !memWr, "R12", "reset memory requests", {30'd0, memRd, memWr}, 32'd0);

    runOp(3'd0, 2'd0, 32'h80, 32'h10, 32'd5, "R1", 1'b0);
    runOp(3'd1, 2'd0, 32'h9F, 32'h2F, 32'd4, "R2", 1'b0);
    putBytes(32'h30, 32'h0044_3322, 4);
    runOp(3'd2, 2'd0, 32'hA0, 32'h30, 32'd10, "R3", 1'b0);
    runOp(3'd2, 2'd0, 32'hB0, 32'h40, 32'd3, "R3", 1'b0);
    runOp(3'd3, 2'd0, 32'hC0, 32'h1234_56AB, 32'd3, "R4", 1'b0);
    runOp(3'd3, 2'd1, 32'hC8, 32'h1234_56AB, 32'd2, "R4", 1'b0);
    runOp(3'd3, 2'd3, 32'hD0, 32'h1234_56AB, 32'd2, "R4", 1'b0);
    putBytes(32'h64, 32'h5A, 1);
    runOp(3'd4, 2'd0, 32'h60, 32'hFFFF_FF5A, 32'd8, "R7", 1'b0);
    runOp(3'd4, 2'd2, 32'h68, 32'hDEAD_BEEF, 32'd3, "R5", 1'b0);
    putBytes(32'h70, 32'h1111_1111, 4);
    putBytes(32'h74, 32'h2222, 2);
    runOp(3'd5, 2'd1, 32'h70, 32'hAAAA_1111, 32'd5, "R5", 1'b0);
    runOp(3'd4, 2'd0, 32'h70, 32'h11, 32'd0, "R6", 1'b0);
    putBytes(32'hE0, 32'h0062_61, 3);
    putBytes(32'hE8, 32'h0062_61, 3);
    runOp(3'd6, 2'd0, 32'hE0, 32'hE8, 32'd10, "R8", 1'b0);
    putBytes(32'hE0, 32'h7861, 2);
    runOp(3'd6, 2'd0, 32'hE0, 32'hE8, 32'd10, "R9", 1'b0);
    runOp(3'd6, 2'd0, 32'hE8, 32'hE0, 32'd10, "R9", 1'b0);
    runOp(3'd6, 2'd0, 32'hE8, 32'hE0, 32'd0, "R6", 1'b0);
    runOp(3'd6, 2'd0, 32'h70, 32'h72, 32'd2, "R8", 1'b0);
    runOp(3'd0, 2'd0, 32'h90, 32'h20, 32'd0, "R6", 1'b0);
    runOp(3'd3, 2'd2, 32'h90, 32'h5555_5555, 32'd0, "R10", 1'b0);
    runOp(3'd0, 2'd0, 32'h50, 32'h18, 32'd6, "R11", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog global timeout actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule